// File: doc/BRIEF.md
# Write-Back Line Staging Buffer

This block sits between the last-level cache and the DRAM command scheduler and holds dirty cache lines on their way to memory. Evicted lines and lines that the read path has repaired after an error correction both enter the same queue, which keeps them in the order they arrived. While a line waits in the queue, a coherence snoop that names its address is answered from the buffer, as a victim cache would answer it.

The queue is drained in batches. The block keeps the DRAM data bus in the read direction until occupancy climbs to a high mark. It then spends a fixed number of turnaround cycles switching the bus and writes lines until occupancy falls to a low mark, then turns the bus back. A refresh request is released to the DRAM only inside one of these turnaround windows, while the pins are changing direction anyway.

To blunt repeated-write row attacks, the block remembers which line addresses it has written since the last completed refresh. If such an address comes in again, the new copy stays parked in the queue until a refresh-done pulse arrives. A new eviction for an address that is already waiting is merged into the waiting entry instead of taking a second slot.

Top module: `line_drain_buffer`

## Requirements
- R1: After reset both insert readies are high, and `dr_valid`, `bus_write`, `ref_issue` and `snp_hit` are low.
- R2: While occupancy stays below `HI_MARK` and no batch is running, `bus_write` and `dr_valid` stay low and no line leaves.
- R3: On the clock edge that brings occupancy to `HI_MARK`, a turnaround of `TURN_CYC` cycles starts, and `bus_write` is high from the edge after it. The batch then writes lines until occupancy equals `LO_MARK` (or until no line can leave), after which `bus_write` drops.
- R4: Lines leave in arrival order, the oldest line that is not held going first, and each carries the data that was last written into its entry.
- R5: With `snp_valid` high, `snp_hit` and `snp_data` are valid in the same cycle. They report the youngest held copy of `snp_addr`. `snp_hit` is low for an absent address and whenever `snp_valid` is low.
- R6: A line arriving for an address that already waits in the queue, and is not the line currently offered on the output, replaces that entry's data in place. It keeps the entry's queue position and uses no extra slot.
- R7: A line whose address has been written to DRAM since the last `ref_done` pulse, or matches the line currently offered on the output, is held in the queue. Younger lines pass it, and it becomes eligible only after a `ref_done` pulse.
- R8: A `ref_req` pulse is latched and answered by exactly one `ref_issue` pulse. That pulse comes only in the first cycle of a turnaround that sees the request, while `bus_write` is low, `TURN_CYC` cycles before `bus_write` rises when it falls in a read-to-write turn.
- R9: When `DEPTH` lines are held, `ev_ready` and `fix_ready` are both low. Occupancy never exceeds `DEPTH`.
- R10: Corrected lines enter through the `fix_*` port and are queued and drained exactly like evictions. When both ports offer a line in the same cycle, the corrected line is taken and `ev_ready` is low.
- R11: Once `dr_valid` is high, it stays high with `dr_addr` and `dr_data` unchanged until a cycle in which `dr_ready` is high. The entry is freed only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An evicted dirty line is offered |
| ev_ready | output | 1 | Eviction accepted on this edge when both valid and ready are high |
| ev_addr | input | AW | Line address of the eviction |
| ev_data | input | DW | Line data of the eviction |
| fix_valid | input | 1 | A corrected line from the read path is offered |
| fix_ready | output | 1 | Corrected line accepted on this edge when both valid and ready are high |
| fix_addr | input | AW | Line address of the corrected line |
| fix_data | input | DW | Corrected line data |
| snp_valid | input | 1 | Snoop lookup request |
| snp_addr | input | AW | Snooped line address |
| snp_hit | output | 1 | Snooped line is held in the buffer |
| snp_data | output | DW | Youngest held data for the snooped line |
| dr_valid | output | 1 | A line is offered to the DRAM scheduler |
| dr_ready | input | 1 | DRAM scheduler takes the offered line |
| dr_addr | output | AW | Address of the offered line |
| dr_data | output | DW | Data of the offered line |
| bus_write | output | 1 | Data bus is in the write direction |
| ref_req | input | 1 | Pulse: a refresh is due |
| ref_issue | output | 1 | Pulse: issue the refresh now |
| ref_done | input | 1 | Pulse: a refresh has completed |

## Verification
The bench measures the turnaround from the edge that reaches the high mark to the first write cycle, so a design that switched the bus early or late is caught. It also counts the lines in each batch, which catches a design that overshoots or stops short of the low mark. It writes a line, brings it back, and checks that the batch skips the line until a refresh completes. A design that forgot written addresses, or that let a duplicate of the line on the output slip through, would write the same row twice. A merged eviction must leave one entry with the newest data in the older slot, and a snoop of a duplicated address must return the newest copy. It also checks that a refresh request waits for a turnaround instead of going out at once, that a full queue drops both readies, and that a corrected line offered beside an eviction wins the slot.

// File: rtl/ldb_pkg.sv
package ldb_pkg;

  typedef enum logic [1:0] {
    ST_READ   = 2'd0,
    ST_TURN_W = 2'd1,
    ST_WRITE  = 2'd2,
    ST_TURN_R = 2'd3
  } ldb_state_e;

  // Occupancy has reached the mark that opens a write batch.
  function automatic logic reached_high(input int unsigned occ, input int unsigned hi);
    return occ >= hi;
  endfunction

  // A batch may take one more line only while occupancy is above the low mark.
  function automatic logic above_low(input int unsigned occ, input int unsigned lo);
    return occ > lo;
  endfunction

endpackage

// File: rtl/ldb_store.sv
module ldb_store #(
  parameter int DEPTH = 128,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [AW-1:0]    ins_addr,
  input  logic [DW-1:0]    ins_data,
  input  logic             ins_hold,
  input  logic             busy_vld,
  input  logic [IW-1:0]    busy_idx,
  input  logic             rm_en,
  input  logic [IW-1:0]    rm_idx,
  input  logic             clr_hold,
  input  logic [IW-1:0]    rd_idx,
  output logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic [AW-1:0]    snp_addr,
  output logic             snp_hit,
  output logic [DW-1:0]    snp_data,
  output logic [CW-1:0]    count,
  output logic [DEPTH-1:0] hold_vec,
  output logic             merge_hit
);

  logic [AW-1:0]    a_q [DEPTH];
  logic [DW-1:0]    d_q [DEPTH];
  logic [DEPTH-1:0] h_q;
  logic [CW-1:0]    cnt_q;

  logic [AW-1:0]    a_n [DEPTH];
  logic [DW-1:0]    d_n [DEPTH];
  logic [DEPTH-1:0] h_n;
  logic [CW-1:0]    cnt_n;

  logic [IW-1:0]    mg_idx;
  int               slot;

  assign count    = cnt_q;
  assign hold_vec = h_q;
  assign rd_addr  = a_q[rd_idx];
  assign rd_data  = d_q[rd_idx];

  // Youngest waiting copy that is not the line on the output port.
  always_comb begin
    merge_hit = 1'b0;
    mg_idx    = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (j < int'(cnt_q) && a_q[j] == ins_addr &&
          !(busy_vld && int'(busy_idx) == j)) begin
        merge_hit = 1'b1;
        mg_idx    = IW'(j);
      end
    end
  end

  // Snoop: the last match in age order is the youngest copy.
  always_comb begin
    snp_hit  = 1'b0;
    snp_data = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (j < int'(cnt_q) && a_q[j] == snp_addr) begin
        snp_hit  = 1'b1;
        snp_data = d_q[j];
      end
    end
  end

  // Next state: close the gap left by a departing line, then merge or append.
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      int src;
      src = (rm_en && j >= int'(rm_idx) && j < DEPTH - 1) ? j + 1 : j;
      a_n[j] = a_q[src];
      d_n[j] = d_q[src];
      h_n[j] = h_q[src];
    end
    if (clr_hold) h_n = '0;
    cnt_n = cnt_q - CW'(rm_en);
    slot  = 0;
    if (ins_en) begin
      if (merge_hit) begin
        slot = int'(mg_idx);
        if (rm_en && mg_idx > rm_idx) slot = slot - 1;
        d_n[slot] = ins_data;
      end else begin
        slot      = int'(cnt_n);
        a_n[slot] = ins_addr;
        d_n[slot] = ins_data;
        h_n[slot] = ins_hold;
        cnt_n     = cnt_n + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      h_q   <= '0;
    end else begin
      cnt_q <= cnt_n;
      h_q   <= h_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < DEPTH; j++) begin
      a_q[j] <= a_n[j];
      d_q[j] <= d_n[j];
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);

  p_merge_no_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && merge_hit && !rm_en) |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/ldb_recent.sv
module ldb_recent #(
  parameter int TBL = 64,
  parameter int AW  = 32,
  localparam int PW = $clog2(TBL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_en,
  input  logic [AW-1:0] rec_addr,
  input  logic          clr,
  input  logic [AW-1:0] look_addr,
  output logic          look_hit,
  output logic          full
);

  logic [AW-1:0] ta_q [TBL];
  logic [PW-1:0] fill_q;
  logic [PW-1:0] base;

  assign full = int'(fill_q) == TBL;
  assign base = clr ? '0 : fill_q;

  always_comb begin
    look_hit = 1'b0;
    for (int j = 0; j < TBL; j++) begin
      if (j < int'(fill_q) && ta_q[j] == look_addr) look_hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else begin
      fill_q <= base + PW'(rec_en);
    end
  end

  always_ff @(posedge clk) begin
    if (rec_en) ta_q[base] <= rec_addr;
  end

  p_tbl_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_en && !clr) |-> !full);

endmodule

// File: rtl/ldb_sched.sv
module ldb_sched
  import ldb_pkg::*;
#(
  parameter int CW = 8,
  parameter int HI = 96,
  parameter int LO = 32,
  parameter int TA = 2,
  localparam int TW = (TA > 1) ? $clog2(TA) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [CW-1:0] occ,
  input  logic       wr_can,
  input  logic       ref_req,
  output ldb_state_e st,
  output logic       bus_write,
  output logic       ref_issue,
  output logic       dr_go
);

  ldb_state_e st_n;
  logic [TW-1:0] tcnt_q;
  logic          pend_q;
  logic          turning;
  logic          more;
  logic          turn_end;

  assign turning   = (st == ST_TURN_W) || (st == ST_TURN_R);
  assign turn_end  = tcnt_q == TW'(TA - 1);
  assign ref_issue = turning && pend_q;
  assign more      = wr_can && above_low(int'(occ), LO);
  assign bus_write = st == ST_WRITE;
  assign dr_go     = bus_write && more;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_READ:   if (reached_high(int'(occ), HI)) st_n = ST_TURN_W;
      ST_TURN_W: if (turn_end) st_n = ST_WRITE;
      ST_WRITE:  if (!more) st_n = ST_TURN_R;
      ST_TURN_R: if (turn_end) st_n = ST_READ;
      default:   st_n = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_READ;
      tcnt_q <= '0;
      pend_q <= 1'b0;
    end else begin
      st     <= st_n;
      tcnt_q <= (turning && !turn_end) ? tcnt_q + TW'(1) : '0;
      pend_q <= ref_req | (pend_q & ~ref_issue);
    end
  end

  p_turn_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ) |=> (st != ST_WRITE));

  p_ref_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_issue && !ref_req) |=> !ref_issue);

endmodule

// File: rtl/line_drain_buffer.sv
module line_drain_buffer
  import ldb_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int AW       = 32,
  parameter int DW       = 64,
  parameter int HI_MARK  = 96,
  parameter int LO_MARK  = 32,
  parameter int TBL      = 64,
  parameter int TURN_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic [AW-1:0] ev_addr,
  input  logic [DW-1:0] ev_data,
  input  logic          fix_valid,
  output logic          fix_ready,
  input  logic [AW-1:0] fix_addr,
  input  logic [DW-1:0] fix_data,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_hit,
  output logic [DW-1:0] snp_data,
  output logic          dr_valid,
  input  logic          dr_ready,
  output logic [AW-1:0] dr_addr,
  output logic [DW-1:0] dr_data,
  output logic          bus_write,
  input  logic          ref_req,
  output logic          ref_issue,
  input  logic          ref_done
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [CW-1:0]    count;
  logic [DEPTH-1:0] hold_vec;
  logic             merge_hit;
  logic             room;
  logic             ins_en;
  logic [AW-1:0]    ins_addr;
  logic [DW-1:0]    ins_data;
  logic             ins_hold;
  logic             tbl_hit;
  logic             tbl_full;
  logic             any_elig;
  logic [IW-1:0]    first_idx;
  logic [IW-1:0]    sel_idx;
  logic             lock_q;
  logic [IW-1:0]    lock_idx_q;
  logic             wr_can;
  logic             accept;
  logic             st_hit;
  ldb_state_e       st;

  // Insert side: a corrected line wins over an eviction.
  assign room      = int'(count) < DEPTH;
  assign fix_ready = room;
  assign ev_ready  = room && !fix_valid;
  assign ins_en    = room && (fix_valid || ev_valid);
  assign ins_addr  = fix_valid ? fix_addr : ev_addr;
  assign ins_data  = fix_valid ? fix_data : ev_data;
  assign ins_hold  = (dr_valid && dr_addr == ins_addr) || (!ref_done && tbl_hit);

  // Oldest line not waiting for a refresh.
  always_comb begin
    any_elig  = 1'b0;
    first_idx = '0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      if (j < int'(count) && !hold_vec[j]) begin
        any_elig  = 1'b1;
        first_idx = IW'(j);
      end
    end
  end

  assign sel_idx = lock_q ? lock_idx_q : first_idx;
  assign wr_can  = lock_q || (any_elig && !tbl_full);
  assign accept  = dr_valid && dr_ready;
  assign snp_hit = snp_valid && st_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= dr_valid && !dr_ready;
      lock_idx_q <= sel_idx;
    end
  end

  ldb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_en   (ins_en),
    .ins_addr (ins_addr),
    .ins_data (ins_data),
    .ins_hold (ins_hold),
    .busy_vld (dr_valid),
    .busy_idx (sel_idx),
    .rm_en    (accept),
    .rm_idx   (sel_idx),
    .clr_hold (ref_done),
    .rd_idx   (sel_idx),
    .rd_addr  (dr_addr),
    .rd_data  (dr_data),
    .snp_addr (snp_addr),
    .snp_hit  (st_hit),
    .snp_data (snp_data),
    .count    (count),
    .hold_vec (hold_vec),
    .merge_hit(merge_hit)
  );

  ldb_recent #(.TBL(TBL), .AW(AW)) u_recent (
    .clk      (clk),
    .rst_n    (rst_n),
    .rec_en   (accept),
    .rec_addr (dr_addr),
    .clr      (ref_done),
    .look_addr(ins_addr),
    .look_hit (tbl_hit),
    .full     (tbl_full)
  );

  ldb_sched #(.CW(CW), .HI(HI_MARK), .LO(LO_MARK), .TA(TURN_CYC)) u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .occ      (count),
    .wr_can   (wr_can),
    .ref_req  (ref_req),
    .st       (st),
    .bus_write(bus_write),
    .ref_issue(ref_issue),
    .dr_go    (dr_valid)
  );

  p_out_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) && $stable(dr_data)));

  p_ref_off_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_issue |-> !bus_write);

  p_no_held_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid |-> !hold_vec[sel_idx]);

  p_full_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) == DEPTH) |-> (!ev_ready && !fix_ready));

  p_batch_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> above_low(int'(count), LO_MARK));

endmodule

// File: tb/line_drain_buffer_tb.sv
`timescale 1ns/1ps
module line_drain_buffer_tb;

  localparam int DEPTH = 16;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int HI    = 12;
  localparam int LO    = 4;
  localparam int TBL   = 24;
  localparam int TA    = 2;
  localparam int BATCH = HI - LO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0, fix_valid = 1'b0, snp_valid = 1'b0;
  logic dr_ready = 1'b0, ref_req = 1'b0, ref_done = 1'b0;
  logic [AW-1:0] ev_addr = '0, fix_addr = '0, snp_addr = '0;
  logic [DW-1:0] ev_data = '0, fix_data = '0;
  logic ev_ready, fix_ready, snp_hit, dr_valid, bus_write, ref_issue;
  logic [DW-1:0] snp_data, dr_data;
  logic [AW-1:0] dr_addr;

  always #2.5 clk = ~clk;

  line_drain_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .HI_MARK(HI), .LO_MARK(LO),
                      .TBL(TBL), .TURN_CYC(TA)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr), .ev_data(ev_data),
    .fix_valid(fix_valid), .fix_ready(fix_ready), .fix_addr(fix_addr), .fix_data(fix_data),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_hit(snp_hit), .snp_data(snp_data),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_data(dr_data),
    .bus_write(bus_write), .ref_req(ref_req), .ref_issue(ref_issue), .ref_done(ref_done)
  );

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  // Monitor of the DRAM side
  logic [AW-1:0] got_a [512];
  logic [DW-1:0] got_d [512];
  int n_got = 0, n_ref = 0, cyc = 0, ref_cyc = 0, rise_cyc = 0;
  logic bw_prev = 1'b0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (dr_valid && dr_ready && n_got < 512) begin
      got_a[n_got] = dr_addr;
      got_d[n_got] = dr_data;
      n_got = n_got + 1;
    end
    if (ref_issue) begin
      n_ref   = n_ref + 1;
      ref_cyc = cyc;
    end
    if (bus_write && !bw_prev) rise_cyc = cyc;
    bw_prev = bus_write;
  end

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a, a ^ 16'h5A3C};
  endfunction

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ev_valid = 0; fix_valid = 0; snp_valid = 0; dr_ready = 0; ref_req = 0; ref_done = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic ins_ev(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ev_valid = 1'b1; ev_addr = a; ev_data = d;
    while (!ev_ready) @(negedge clk);
    @(posedge clk);
    #1 ev_valid = 1'b0;
  endtask

  task automatic wait_drain();
    logic seen;
    seen = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (bus_write) seen = 1'b1;
      if (seen && !bus_write) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) ref_req = 1'b1; else ref_done = 1'b1;
    @(negedge clk);
    ref_req = 1'b0; ref_done = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(ev_ready && fix_ready, "R1 readies", {ev_ready, fix_ready}, 2'b11);
    chk(!dr_valid && !bus_write, "R1 drain idle", {dr_valid, bus_write}, 0);
    chk(!ref_issue && !snp_hit, "R1 refresh/snoop idle", {ref_issue, snp_hit}, 0);
  endtask

  task automatic t_batch();
    int base, n;
    do_reset();
    dr_ready = 1'b1;
    base = n_got;
    for (int i = 0; i < HI - 1; i++) ins_ev(16'h0100 + 16'(i), pat(16'h0100 + 16'(i)));
    repeat (20) @(negedge clk);
    chk(n_got == base && !bus_write, "R2 no drain below high mark", n_got - base, 0);
    ins_ev(16'h0100 + 16'(HI - 1), pat(16'h0100 + 16'(HI - 1)));
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (bus_write) break;
      n++;
    end
    chk(n == TA + 1, "R3 turnaround length", n, TA + 1);
    wait_drain();
    chk(n_got - base == BATCH, "R3 batch stops at low mark", n_got - base, BATCH);
    for (int i = 0; i < BATCH; i++) begin
      chk(got_a[base + i] == 16'h0100 + 16'(i) && got_d[base + i] == pat(16'h0100 + 16'(i)),
          "R4 arrival order", got_a[base + i], 16'h0100 + i);
    end
    // R5 snoop of held and absent lines
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = 16'h0100 + 16'(BATCH);
    #1 chk(snp_hit && snp_data == pat(snp_addr), "R5 snoop hit", snp_data, pat(snp_addr));
    snp_addr = 16'h0100;
    #1 chk(!snp_hit, "R5 snoop miss on written line", snp_hit, 0);
    snp_valid = 1'b0; snp_addr = 16'h0100 + 16'(BATCH);
    #1 chk(!snp_hit, "R5 no hit without snp_valid", snp_hit, 0);
  endtask

  task automatic t_merge();
    int base;
    do_reset();
    base = n_got;
    ins_ev(16'h0200, 32'h1111_0001);
    ins_ev(16'h0201, pat(16'h0201));
    ins_ev(16'h0200, 32'h2222_0002);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = 16'h0200;
    #1 chk(snp_hit && snp_data == 32'h2222_0002, "R6 merged data", snp_data, 32'h2222_0002);
    snp_valid = 1'b0;
    for (int i = 0; i < HI - 2; i++) ins_ev(16'h0300 + 16'(i), pat(16'h0300 + 16'(i)));
    repeat (TA + 4) @(negedge clk);
    chk(dr_valid && dr_addr == 16'h0200, "R11 offered line held", dr_addr, 16'h0200);
    repeat (3) @(negedge clk);
    chk(dr_valid && dr_addr == 16'h0200 && dr_data == 32'h2222_0002,
        "R11 offer stable without ready", dr_data, 32'h2222_0002);
    ins_ev(16'h0200, 32'h3333_0003);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = 16'h0200;
    #1 chk(snp_hit && snp_data == 32'h3333_0003, "R5 youngest copy", snp_data, 32'h3333_0003);
    snp_valid = 1'b0;
    chk(dr_addr == 16'h0200 && dr_data == 32'h2222_0002, "R11 offer kept after insert",
        dr_data, 32'h2222_0002);
    dr_ready = 1'b1;
    wait_drain();
    chk(n_got - base == BATCH + 1, "R6 one slot per address", n_got - base, BATCH + 1);
    chk(got_a[base] == 16'h0200 && got_d[base] == 32'h2222_0002, "R6 merged line first",
        got_d[base], 32'h2222_0002);
    chk(got_a[base + 1] == 16'h0201, "R4 second line", got_a[base + 1], 16'h0201);
    chk(got_a[base + 2] == 16'h0300, "R6 no duplicate entry", got_a[base + 2], 16'h0300);
    for (int i = 1; i < BATCH + 1; i++)
      chk(got_a[base + i] != 16'h0200, "R7 duplicate of offered line held", got_a[base + i], 0);
  endtask

  task automatic t_repeat();
    int base, refs;
    logic hit;
    do_reset();
    dr_ready = 1'b1;
    ins_ev(16'h0400, pat(16'h0400));
    for (int i = 0; i < HI - 1; i++) ins_ev(16'h0410 + 16'(i), pat(16'h0410 + 16'(i)));
    wait_drain();
    refs = n_ref;
    pulse(0);
    repeat (10) @(negedge clk);
    chk(n_ref == refs, "R8 refresh waits for turnaround", n_ref - refs, 0);
    base = n_got;
    ins_ev(16'h0400, pat(16'h0400));
    for (int i = 0; i < BATCH - 1; i++) ins_ev(16'h0420 + 16'(i), pat(16'h0420 + 16'(i)));
    wait_drain();
    chk(n_ref == refs + 1, "R8 one refresh pulse", n_ref - refs, 1);
    chk(rise_cyc - ref_cyc == TA, "R8 refresh inside turnaround", rise_cyc - ref_cyc, TA);
    chk(n_got - base == BATCH, "R7 younger lines pass", n_got - base, BATCH);
    hit = 1'b0;
    for (int i = 0; i < BATCH; i++) if (got_a[base + i] == 16'h0400) hit = 1'b1;
    chk(!hit, "R7 rewrite held before refresh", hit, 0);
    pulse(1);
    base = n_got;
    for (int i = 0; i < BATCH; i++) ins_ev(16'h0430 + 16'(i), pat(16'h0430 + 16'(i)));
    wait_drain();
    chk(n_got > base && got_a[base] == 16'h0400, "R7 released after refresh",
        got_a[base], 16'h0400);
  endtask

  task automatic t_full();
    int base;
    do_reset();
    base = n_got;
    @(negedge clk);
    fix_valid = 1'b1; fix_addr = 16'h0500; fix_data = pat(16'h0500);
    ev_valid = 1'b1;  ev_addr = 16'h0600;  ev_data = pat(16'h0600);
    #1 chk(!ev_ready && fix_ready, "R10 corrected line wins", {ev_ready, fix_ready}, 2'b01);
    @(posedge clk);
    #1 fix_valid = 1'b0;
    while (!ev_ready) @(negedge clk);
    @(posedge clk);
    #1 ev_valid = 1'b0;
    for (int i = 0; i < DEPTH - 2; i++) ins_ev(16'h0601 + 16'(i), pat(16'h0601 + 16'(i)));
    @(negedge clk);
    chk(!ev_ready && !fix_ready, "R9 full stalls both ports", {ev_ready, fix_ready}, 0);
    repeat (TA + 2) @(negedge clk);
    chk(dr_valid && dr_addr == 16'h0500, "R10 corrected line offered first", dr_addr, 16'h0500);
    dr_ready = 1'b1;
    wait_drain();
    chk(ev_ready, "R9 ready returns after drain", ev_ready, 1);
    chk(n_got - base == DEPTH - LO, "R3 batch from full", n_got - base, DEPTH - LO);
    chk(got_a[base] == 16'h0500 && got_d[base] == pat(16'h0500), "R10 corrected data",
        got_d[base], pat(16'h0500));
    chk(got_a[base + 1] == 16'h0600 && got_a[base + 2] == 16'h0601, "R4 order after full",
        got_a[base + 2], 16'h0601);
  endtask

  initial begin
    t_reset();
    t_batch();
    t_merge();
    t_repeat();
    t_full();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule